// File: doc/BRIEF.md
# Instruction Phase Sequencer

This block is the control state machine of a small 16-bit load/store processor whose datapath shares one bus. It moves every instruction through up to six phases: fetch, decode, address evaluation, operand fetch, execute and result store. Each opcode skips the phases it has no use for. In every state it drives the bus-gate selects, the register load enables, the ALU operation, the PC source select, the memory strobes and the condition-code load enable. The datapath itself (PC, MAR, MDR, IR, register file, ALU and memory) lies outside the block and acts on these outputs.

Inputs are the opcode field of the instruction register, a memory ready handshake and a branch-condition match computed by the datapath. The supported opcodes are add, bitwise and, bitwise not, base-plus-offset load, base-plus-offset store and conditional branch. Every other opcode ends right after decode.

Top module: `phase_seq`

## Requirements
- R1: While `rst` is high every enable, gate and strobe output is 0. The first cycle after `rst` falls, and also after a reset in mid-instruction, is the fetch cycle with `gate_pc` and `ld_mar` set.
- R2: Fetch takes one cycle with `gate_pc`+`ld_mar`. It then reads with `mem_rd`, and `ld_mdr` rises only in the cycle `mem_ready` is high. Next comes one cycle with `gate_mdr`+`ld_ir`+`ld_pc` and `pc_sel`=0 (increment). Last comes one decode cycle with every enable low.
- R3: No more than one of `gate_pc`, `gate_alu`, `gate_mdr`, `gate_addr` is high in any cycle.
- R4: `phase` encodes fetch=0, decode=1, evaluate address=2, fetch operands=3, execute=4, store=5. Within an instruction it never decreases, and it returns to 0 only when a new instruction starts.
- R5: Add (0001), and (0101) and not (1001) give, after decode, one operand cycle (phase 3) with no enables. A store cycle (phase 5) follows with `gate_alu`, `ld_reg`, `ld_cc` and `alu_op` = 00, 01 or 10 respectively.
- R6: Load (0110) gives one cycle with `gate_addr`+`ld_mar` (phase 2). A read follows (phase 3) that holds until ready, and then a cycle with `gate_mdr`+`ld_reg`+`ld_cc` (phase 5).
- R7: Store (0111) gives one `gate_addr`+`ld_mar` cycle. Then comes one cycle with `gate_alu`, `alu_op`=11 (pass) and `ld_mdr`. Then `mem_wr` (phase 5) holds until ready. It never raises `ld_reg` or `ld_cc`.
- R8: Branch (0000) gives one execute cycle (phase 4) with `pc_sel`=1 (address adder) and `ld_pc` equal to `cond_met`.
- R9: Every other opcode goes from decode straight to the fetch cycle, with no enable or strobe raised.
- R10: `ld_cc` is raised only for an instruction whose opcode is add, and, not or load.
- R11: `mem_rd` and `mem_wr` are never high together. While `mem_ready` is low a memory cycle repeats with identical outputs.
- R12: The opcode is captured at decode. A change on `opcode` after decode has no effect on the rest of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| mem_ready | input | 1 | Memory access completes this cycle |
| cond_met | input | 1 | Branch condition matches the condition codes |
| gate_pc | output | 1 | PC drives the bus |
| gate_alu | output | 1 | ALU result drives the bus |
| gate_mdr | output | 1 | MDR drives the bus |
| gate_addr | output | 1 | Address adder drives the bus |
| ld_mar | output | 1 | MAR loads from the bus |
| ld_mdr | output | 1 | MDR loads (memory on read, bus otherwise) |
| ld_ir | output | 1 | IR loads from the bus |
| ld_pc | output | 1 | PC loads from the selected source |
| ld_reg | output | 1 | Register file writes the bus value |
| ld_cc | output | 1 | Condition codes update from the bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_sel | output | 1 | PC source: 0 increment, 1 address adder |
| alu_op | output | 2 | ALU select: 00 add, 01 and, 10 not, 11 pass |
| phase | output | 3 | Current instruction phase code |

## Verification
The bench runs all sixteen opcodes. Each one runs with zero, one and three memory wait cycles and with the branch condition both false and true, and every output vector is compared in every cycle. The wait counts separate a correct ready hold from a state that advances too early. The two condition values separate a conditional PC load from one that always or never fires. Changing the opcode after decode on the one-wait pass shows whether the ALU select and condition-code enable come from the captured value or from the live input. A reset in the middle of a pending load read shows whether the sequence is abandoned cleanly.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    localparam int OPC_W     = 4;
    localparam int NUM_OPS   = 1 << OPC_W;
    localparam int PHASE_W   = 3;
    localparam int ALU_SEL_W = 2;

    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_BR  = 4'h0;
    localparam opc_t OPC_ADD = 4'h1;
    localparam opc_t OPC_LD  = 4'h2;
    localparam opc_t OPC_AND = 4'h5;
    localparam opc_t OPC_LDR = 4'h6;
    localparam opc_t OPC_STR = 4'h7;
    localparam opc_t OPC_NOT = 4'h9;
    localparam opc_t OPC_LDI = 4'hA;
    localparam opc_t OPC_LEA = 4'hE;

    typedef enum logic [ALU_SEL_W-1:0] {
        ALU_ADD  = 2'b00,
        ALU_AND  = 2'b01,
        ALU_NOT  = 2'b10,
        ALU_PASS = 2'b11
    } alu_op_e;

    typedef enum logic [PHASE_W-1:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EVAL   = 3'd2,
        PH_OPND   = 3'd3,
        PH_EXEC   = 3'd4,
        PH_STORE  = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        PATH_NONE,
        PATH_ALU,
        PATH_LOAD,
        PATH_STORE,
        PATH_BRANCH
    } path_e;

    typedef enum logic [3:0] {
        ST_F_ADDR,
        ST_F_READ,
        ST_F_IR,
        ST_DECODE,
        ST_ALU_OPND,
        ST_ALU_WB,
        ST_MEM_EA,
        ST_LD_READ,
        ST_LD_WB,
        ST_ST_DATA,
        ST_ST_WRITE,
        ST_BR_EXEC
    } state_e;

    typedef enum logic {
        PC_INC  = 1'b0,
        PC_ADDR = 1'b1
    } pc_sel_e;

    typedef struct packed {
        logic    gate_pc;
        logic    gate_alu;
        logic    gate_mdr;
        logic    gate_addr;
        logic    ld_mar;
        logic    ld_mdr;
        logic    ld_ir;
        logic    ld_pc;
        logic    ld_reg;
        logic    ld_cc;
        logic    mem_rd;
        logic    mem_wr;
        pc_sel_e pc_sel;
        alu_op_e alu_op;
    } ctrl_t;

    // Which control path a decoded opcode line selects.
    function automatic path_e path_of(opc_t op);
        case (op)
            OPC_ADD, OPC_AND, OPC_NOT: return PATH_ALU;
            OPC_LDR:                   return PATH_LOAD;
            OPC_STR:                   return PATH_STORE;
            OPC_BR:                    return PATH_BRANCH;
            default:                   return PATH_NONE;
        endcase
    endfunction

    // Opcodes permitted to update the condition codes.
    function automatic logic cc_allowed(opc_t op);
        case (op)
            OPC_ADD, OPC_AND, OPC_NOT,
            OPC_LD, OPC_LDI, OPC_LDR, OPC_LEA: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic alu_op_e alu_of(opc_t op);
        case (op)
            OPC_ADD: return ALU_ADD;
            OPC_AND: return ALU_AND;
            OPC_NOT: return ALU_NOT;
            default: return ALU_PASS;
        endcase
    endfunction

    function automatic phase_e phase_of(state_e s);
        case (s)
            ST_F_ADDR, ST_F_READ, ST_F_IR: return PH_FETCH;
            ST_DECODE:                     return PH_DECODE;
            ST_MEM_EA:                     return PH_EVAL;
            ST_ALU_OPND, ST_LD_READ,
            ST_ST_DATA:                    return PH_OPND;
            ST_BR_EXEC:                    return PH_EXEC;
            ST_ALU_WB, ST_LD_WB,
            ST_ST_WRITE:                   return PH_STORE;
            default:                       return PH_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/phase_seq_decode.sv
module phase_seq_decode
    import phase_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opc_t  opcode,
    input  logic  capture,
    output path_e path_now,
    output path_e path_q,
    output opc_t  op_q
);

    logic [NUM_OPS-1:0] hot;

    // One line per opcode value.
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_line
        assign hot[i] = (opcode == opc_t'(i));
    end

    always_comb begin
        path_now = PATH_NONE;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (hot[i]) begin
                path_now = path_of(opc_t'(i));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= PATH_NONE;
            op_q   <= '0;
        end else if (capture) begin
            path_q <= path_now;
            op_q   <= opcode;
        end
    end

endmodule

// File: rtl/phase_seq_fsm.sv
module phase_seq_fsm
    import phase_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mem_ready,
    input  path_e  path_now,
    input  path_e  path_q,
    output state_e state
);

    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_F_ADDR:   nxt = ST_F_READ;
            ST_F_READ:   nxt = mem_ready ? ST_F_IR : ST_F_READ;
            ST_F_IR:     nxt = ST_DECODE;
            ST_DECODE: begin
                case (path_now)
                    PATH_ALU:              nxt = ST_ALU_OPND;
                    PATH_LOAD, PATH_STORE: nxt = ST_MEM_EA;
                    PATH_BRANCH:           nxt = ST_BR_EXEC;
                    default:               nxt = ST_F_ADDR;
                endcase
            end
            ST_ALU_OPND: nxt = ST_ALU_WB;
            ST_ALU_WB:   nxt = ST_F_ADDR;
            ST_MEM_EA:   nxt = (path_q == PATH_STORE) ? ST_ST_DATA : ST_LD_READ;
            ST_LD_READ:  nxt = mem_ready ? ST_LD_WB : ST_LD_READ;
            ST_LD_WB:    nxt = ST_F_ADDR;
            ST_ST_DATA:  nxt = ST_ST_WRITE;
            ST_ST_WRITE: nxt = mem_ready ? ST_F_ADDR : ST_ST_WRITE;
            ST_BR_EXEC:  nxt = ST_F_ADDR;
            default:     nxt = ST_F_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_F_ADDR;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/phase_seq_ctrl.sv
module phase_seq_ctrl
    import phase_seq_pkg::*;
(
    input  logic   rst,
    input  state_e state,
    input  logic   mem_ready,
    input  logic   cond_met,
    input  opc_t   op_q,
    output ctrl_t  ctrl,
    output phase_e phase
);

    always_comb begin
        ctrl = '0;
        case (state)
            ST_F_ADDR: begin
                ctrl.gate_pc = 1'b1;
                ctrl.ld_mar  = 1'b1;
            end
            ST_F_READ, ST_LD_READ: begin
                ctrl.mem_rd = 1'b1;
                ctrl.ld_mdr = mem_ready;
            end
            ST_F_IR: begin
                ctrl.gate_mdr = 1'b1;
                ctrl.ld_ir    = 1'b1;
                ctrl.ld_pc    = 1'b1;
                ctrl.pc_sel   = PC_INC;
            end
            ST_ALU_WB: begin
                ctrl.gate_alu = 1'b1;
                ctrl.ld_reg   = 1'b1;
                ctrl.ld_cc    = cc_allowed(op_q);
                ctrl.alu_op   = alu_of(op_q);
            end
            ST_MEM_EA: begin
                ctrl.gate_addr = 1'b1;
                ctrl.ld_mar    = 1'b1;
            end
            ST_LD_WB: begin
                ctrl.gate_mdr = 1'b1;
                ctrl.ld_reg   = 1'b1;
                ctrl.ld_cc    = cc_allowed(op_q);
            end
            ST_ST_DATA: begin
                ctrl.gate_alu = 1'b1;
                ctrl.alu_op   = ALU_PASS;
                ctrl.ld_mdr   = 1'b1;
            end
            ST_ST_WRITE: begin
                ctrl.mem_wr = 1'b1;
            end
            ST_BR_EXEC: begin
                ctrl.ld_pc  = cond_met;
                ctrl.pc_sel = PC_ADDR;
            end
            default: ctrl = '0;
        endcase
        if (rst) begin
            ctrl = '0;
        end
    end

    assign phase = phase_of(state);

endmodule

// File: rtl/phase_seq.sv
module phase_seq
    import phase_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode,
    input  logic                 mem_ready,
    input  logic                 cond_met,
    output logic                 gate_pc,
    output logic                 gate_alu,
    output logic                 gate_mdr,
    output logic                 gate_addr,
    output logic                 ld_mar,
    output logic                 ld_mdr,
    output logic                 ld_ir,
    output logic                 ld_pc,
    output logic                 ld_reg,
    output logic                 ld_cc,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 pc_sel,
    output logic [ALU_SEL_W-1:0] alu_op,
    output logic [PHASE_W-1:0]   phase
);

    state_e state;
    path_e  path_now;
    path_e  path_q;
    opc_t   op_q;
    ctrl_t  ctrl;
    phase_e ph;

    phase_seq_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .capture  (state == ST_DECODE),
        .path_now (path_now),
        .path_q   (path_q),
        .op_q     (op_q)
    );

    phase_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mem_ready (mem_ready),
        .path_now  (path_now),
        .path_q    (path_q),
        .state     (state)
    );

    phase_seq_ctrl u_ctrl (
        .rst       (rst),
        .state     (state),
        .mem_ready (mem_ready),
        .cond_met  (cond_met),
        .op_q      (op_q),
        .ctrl      (ctrl),
        .phase     (ph)
    );

    assign gate_pc   = ctrl.gate_pc;
    assign gate_alu  = ctrl.gate_alu;
    assign gate_mdr  = ctrl.gate_mdr;
    assign gate_addr = ctrl.gate_addr;
    assign ld_mar    = ctrl.ld_mar;
    assign ld_mdr    = ctrl.ld_mdr;
    assign ld_ir     = ctrl.ld_ir;
    assign ld_pc     = ctrl.ld_pc;
    assign ld_reg    = ctrl.ld_reg;
    assign ld_cc     = ctrl.ld_cc;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign pc_sel    = ctrl.pc_sel;
    assign alu_op    = ctrl.alu_op;
    assign phase     = ph;

endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] opcode,
    input logic       mem_ready,
    input logic       gate_pc,
    input logic       gate_alu,
    input logic       gate_mdr,
    input logic       gate_addr,
    input logic       ld_mar,
    input logic       ld_mdr,
    input logic       ld_ir,
    input logic       ld_pc,
    input logic       ld_reg,
    input logic       ld_cc,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       pc_sel,
    input logic [1:0] alu_op,
    input logic [2:0] phase
);

    logic [3:0] op_seen;
    logic [11:0] enables;

    assign enables = {gate_pc, gate_alu, gate_mdr, gate_addr, ld_mar, ld_mdr,
                      ld_ir, ld_pc, ld_reg, ld_cc, mem_rd, mem_wr};

    always_ff @(posedge clk) begin
        if (rst) begin
            op_seen <= '0;
        end else if (phase == 3'd1) begin
            op_seen <= opcode;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            assert_reset_quiet_R1: assert (enables == '0);
        end
    end

    assert_single_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({gate_pc, gate_alu, gate_mdr, gate_addr}) <= 1);

    assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1) |-> (enables == '0));

    assert_ir_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        ld_ir |-> $past(mem_rd && mem_ready));

    assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |=> (phase == 3'd0 || phase >= $past(phase)));

    assert_store_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_alu && ld_mdr) |-> (alu_op == 2'b11 && !ld_reg && !ld_cc));

    assert_branch_src_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && pc_sel) |-> (phase == 3'd4));

    assert_cc_listed_R10: assert property (@(posedge clk) disable iff (rst)
        ld_cc |-> (op_seen == 4'h1 || op_seen == 4'h5 || op_seen == 4'h9 || op_seen == 4'h6));

    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(phase)));

    assert_write_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> mem_wr);

endmodule

bind phase_seq phase_seq_chk u_chk (.*);

// File: tb/phase_seq_tb.sv
module phase_seq_tb_top;

    localparam time CLK_PERIOD      = 10;
    localparam int  WATCHDOG_CYCLES = 20000;

    // Expected-vector bit masks, order matches the packed vector below.
    localparam logic [14:0] GPC  = 15'h4000;
    localparam logic [14:0] GALU = 15'h2000;
    localparam logic [14:0] GMDR = 15'h1000;
    localparam logic [14:0] GADR = 15'h0800;
    localparam logic [14:0] LMAR = 15'h0400;
    localparam logic [14:0] LMDR = 15'h0200;
    localparam logic [14:0] LIR  = 15'h0100;
    localparam logic [14:0] LPC  = 15'h0080;
    localparam logic [14:0] LREG = 15'h0040;
    localparam logic [14:0] LCC  = 15'h0020;
    localparam logic [14:0] MRD  = 15'h0010;
    localparam logic [14:0] MWR  = 15'h0008;
    localparam logic [14:0] PSEL = 15'h0004;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic       mem_ready = 1'b0;
    logic       cond_met = 1'b0;
    logic       gate_pc, gate_alu, gate_mdr, gate_addr;
    logic       ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc;
    logic       mem_rd, mem_wr, pc_sel;
    logic [1:0] alu_op;
    logic [2:0] phase;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .opcode    (opcode),
        .mem_ready (mem_ready),
        .cond_met  (cond_met),
        .gate_pc   (gate_pc),
        .gate_alu  (gate_alu),
        .gate_mdr  (gate_mdr),
        .gate_addr (gate_addr),
        .ld_mar    (ld_mar),
        .ld_mdr    (ld_mdr),
        .ld_ir     (ld_ir),
        .ld_pc     (ld_pc),
        .ld_reg    (ld_reg),
        .ld_cc     (ld_cc),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pc_sel    (pc_sel),
        .alu_op    (alu_op),
        .phase     (phase)
    );

    wire [14:0] act = {gate_pc, gate_alu, gate_mdr, gate_addr, ld_mar, ld_mdr, ld_ir,
                       ld_pc, ld_reg, ld_cc, mem_rd, mem_wr, pc_sel, alu_op};

    // Compare the current cycle's outputs; eph < 0 means phase not checked.
    task automatic cmp(input logic [14:0] e, input int eph, input string req);
        #1;
        total++;
        if (act !== e || (eph >= 0 && phase !== 3'(eph))) begin
            bad++;
            $display("FAIL %s: ctl=%h phase=%0d expected ctl=%h phase=%0d at %0t",
                     req, act, phase, e, eph, $time);
        end
    endtask

    task automatic chk(input logic [14:0] e, input int eph, input string req);
        cmp(e, eph, req);
        @(negedge clk);
    endtask

    function automatic int path_of_op(int o);
        case (o)
            1, 5, 9: return 1;
            6:       return 2;
            7:       return 3;
            0:       return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [14:0] alu_bits(int o);
        case (o)
            1:       return 15'd0;
            5:       return 15'd1;
            default: return 15'd2;
        endcase
    endfunction

    task automatic run_instr(input int opc, input int waits, input bit cond, input bit scramble);
        cond_met  = cond;
        mem_ready = 1'b0;
        chk(GPC | LMAR, 0, "R2");
        for (int w = 0; w < waits; w++) chk(MRD, 0, "R11");
        mem_ready = 1'b1;
        chk(MRD | LMDR, 0, "R2");
        mem_ready = 1'b0;
        opcode = 4'(opc);
        chk(GMDR | LIR | LPC, 0, "R2");
        chk(15'h0, 1, "R2");
        case (path_of_op(opc))
            1: begin
                if (scramble) opcode = 4'(opc) ^ 4'hC;
                chk(15'h0, 3, "R5");
                chk(GALU | LREG | LCC | alu_bits(opc), 5, scramble ? "R12" : "R5 R10");
            end
            2: begin
                chk(GADR | LMAR, 2, "R6");
                for (int w = 0; w < waits; w++) chk(MRD, 3, "R11");
                mem_ready = 1'b1;
                chk(MRD | LMDR, 3, "R6");
                mem_ready = 1'b0;
                chk(GMDR | LREG | LCC, 5, "R6");
            end
            3: begin
                chk(GADR | LMAR, 2, "R7");
                chk(GALU | LMDR | 15'd3, 3, "R7");
                for (int w = 0; w < waits; w++) chk(MWR, 5, "R11");
                mem_ready = 1'b1;
                chk(MWR, 5, "R7");
                mem_ready = 1'b0;
            end
            4: begin
                chk((cond ? LPC : 15'h0) | PSEL, 4, "R8");
            end
            default: begin
                cmp(GPC | LMAR, 0, "R9");
            end
        endcase
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: ran %0d cycles expected completion", WATCHDOG_CYCLES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp(15'h0, 0, "R1");
        rst = 1'b0;

        // Full sweep: every opcode, three wait depths, both branch outcomes.
        for (int opc = 0; opc < 16; opc++) begin
            for (int wi = 0; wi < 3; wi++) begin
                for (int c = 0; c < 2; c++) begin
                    run_instr(opc, (wi == 2) ? 3 : wi, c[0], wi == 1);
                end
            end
        end

        // Reset while a load read is pending.
        mem_ready = 1'b0;
        chk(GPC | LMAR, 0, "R2");
        mem_ready = 1'b1;
        chk(MRD | LMDR, 0, "R2");
        mem_ready = 1'b0;
        opcode = 4'h6;
        chk(GMDR | LIR | LPC, 0, "R2");
        chk(15'h0, 1, "R2");
        chk(GADR | LMAR, 2, "R6");
        rst = 1'b1;
        chk(15'h0, -1, "R1");
        rst = 1'b0;
        cmp(GPC | LMAR, 0, "R1");
        run_instr(1, 0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule